// File: doc/BRIEF.md
# Key-Protected ADC Conversion Sequencer

This block is the digital control front end of a small eight-way multiplexed analog-to-digital converter. Software reaches it through a simple 32-bit register bus with three locations. One holds the multiplexer switch word. One returns the newest sample and also triggers the next conversion. One takes a one-shot unlock key. The switch word is guarded, so a write to it lands only if the bus write just before it placed the key in the lock location. Any other bus access locks it again.

The converter itself is not part of the block. A sample input port stands in for the converter output, and a pair of down-counters models the settling interval after a channel change and the conversion time. A rate select input picks a fast or a slow conversion clock. Each setting has its own settling and conversion cycle counts, given as parameters. A ready flag, shown both in the result word and on a port, tells software when a fresh sample can be collected.

Top module: `adcseq_ctrl`

## Requirements
- R1: After reset the switch word reads 0, the switch location is locked, `result_ready` is 0 and bit 31 of the result word is 0.
- R2: A write to the switch location (0x18) is stored only when the previous bus access was a write of exactly 0x000000AA to the lock location (0x20). Any other access in between locks it again: a read, a different value, or a write to another address. A rejected write leaves the switch word unchanged.
- R3: An accepted switch write stores the low 12 bits of the write data. Reading 0x18 returns them zero-extended.
- R4: The switch words 0x608, 0x680, 0x640, 0x620, 0x610, 0x601, 0x602 and 0x604 select channels 0 to 7 in that order, shown on `ch_idx`, with `ch_ok` high.
- R5: A read of the result location (0x08) clears ready on the next edge and starts a conversion. With settling over, ready rises exactly CONV edges after the read edge. A read during a conversion restarts it, and the earlier conversion is discarded.
- R6: An accepted switch write clears ready and starts a settling interval of SETTLE edges. A conversion started during settling waits for the interval to end. Ready therefore rises SETTLE+CONV edges after the switch write.
- R7: The result word carries ready in bit 31, zeros in bits 30:16, and the sample in bits 15:0 as two's complement. The sample is captured when the conversion ends and is clamped to the range -25000..+25000.
- R8: A switch word that is not in the R4 list is still stored. It drives `ch_ok` low, and ready stays 0 for any conversion started while it is selected.
- R9: `rate_sel` = 0 uses the fast counts and `rate_sel` = 1 uses the slow counts. The value is taken when each interval is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Bus access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current access, before the edge |
| rate_sel | input | 1 | 0 = fast conversion clock, 1 = slow |
| sample_in | input | 16 | Stand-in converter output, two's complement |
| ch_idx | output | 3 | Decoded channel index |
| ch_ok | output | 1 | Switch word is one of the eight valid codes |
| result_ready | output | 1 | A completed, valid sample is waiting |

## Verification
The bench goes after the lock sequence at its edges. This covers the key written to the wrong address, the wrong key value, and a read placed between key and switch write. A design that kept the unlock alive across an access, or that ignored reads, would take a switch word it should reject. The ready timing is counted edge by edge under both rates and with and without pending settling. An off-by-one counter, or a conversion that runs during settling, would show ready one cycle early or late. A second result read placed inside a running conversion catches designs that fail to restart. Clamping at both limits, and an unlisted switch code, expose a design that passes raw out-of-range samples or flags ready on a dead channel.

// File: rtl/adcseq_pkg.sv
`timescale 1ns/1ps
package adcseq_pkg;
   localparam int NUM_CH     = 8;
   localparam int IDX_W      = $clog2(NUM_CH);
   localparam int OFS_RESULT = 'h08;
   localparam int OFS_SWITCH = 'h18;
   localparam int OFS_LOCK   = 'h20;
   localparam int UNLOCK_KEY = 'hAA;

   typedef enum logic {RATE_FAST = 1'b0, RATE_SLOW = 1'b1} rate_e;

   // switch word for each channel index
   function automatic logic [11:0] ch_code(input int idx);
      case (idx)
         0: ch_code = 12'h608;
         1: ch_code = 12'h680;
         2: ch_code = 12'h640;
         3: ch_code = 12'h620;
         4: ch_code = 12'h610;
         5: ch_code = 12'h601;
         6: ch_code = 12'h602;
         7: ch_code = 12'h604;
         default: ch_code = 12'h000;
      endcase
   endfunction
endpackage

// File: rtl/adcseq_lock.sv
`timescale 1ns/1ps
module adcseq_lock #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int SW_W   = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [SW_W-1:0]   sw_word,
   output logic              sw_load
);
   localparam logic [ADDR_W-1:0] A_SW   = ADDR_W'(adcseq_pkg::OFS_SWITCH);
   localparam logic [ADDR_W-1:0] A_LOCK = ADDR_W'(adcseq_pkg::OFS_LOCK);
   localparam logic [DATA_W-1:0] KEY    = DATA_W'(adcseq_pkg::UNLOCK_KEY);

   if (SW_W < 12 || SW_W > DATA_W) begin : g_bad_sw_w
      $error("adcseq_lock: SW_W out of range");
   end

   logic open_q;
   logic key_hit;
   logic [SW_W-1:0] sw_q;

   assign key_hit = bus_en && bus_we && (bus_addr == A_LOCK) && (bus_wdata == KEY);
   assign sw_load = bus_en && bus_we && (bus_addr == A_SW) && open_q;
   assign sw_word = sw_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         sw_q   <= '0;
      end else begin
         if (bus_en) open_q <= key_hit;
         if (sw_load) sw_q <= bus_wdata[SW_W-1:0];
      end
   end

   // R2: switch write not directly behind a key write leaves the word alone
   a_r2_locked_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && bus_we && bus_addr == A_SW &&
       !$past(bus_en && bus_we && bus_addr == A_LOCK && bus_wdata == KEY))
      |=> $stable(sw_q));
endmodule

// File: rtl/adcseq_chdec.sv
`timescale 1ns/1ps
module adcseq_chdec #(
   parameter int SW_W   = 12,
   parameter int NUM_CH = adcseq_pkg::NUM_CH,
   parameter int IDX_W  = adcseq_pkg::IDX_W
) (
   input  logic [SW_W-1:0]  sw_word,
   output logic [IDX_W-1:0] ch_idx,
   output logic             ch_ok
);
   if (NUM_CH > (1 << IDX_W)) begin : g_bad_idx
      $error("adcseq_chdec: IDX_W too narrow");
   end

   logic [NUM_CH-1:0] hit;

   for (genvar g = 0; g < NUM_CH; g++) begin : g_code
      assign hit[g] = (sw_word == SW_W'(adcseq_pkg::ch_code(g)));
   end

   always_comb begin
      ch_idx = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (hit[i]) ch_idx = IDX_W'(i);
      end
   end

   assign ch_ok = |hit;
endmodule

// File: rtl/adcseq_timer.sv
`timescale 1ns/1ps
module adcseq_timer #(
   parameter int SETTLE_FAST = 6,
   parameter int SETTLE_SLOW = 24,
   parameter int CONV_FAST   = 4,
   parameter int CONV_SLOW   = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rate_sel,
   input  logic settle_start,
   input  logic conv_start,
   input  logic ch_ok,
   output logic capture,
   output logic ready
);
   localparam int MAX_S = (SETTLE_FAST > SETTLE_SLOW) ? SETTLE_FAST : SETTLE_SLOW;
   localparam int MAX_C = (CONV_FAST > CONV_SLOW) ? CONV_FAST : CONV_SLOW;
   localparam int MAX_A = (MAX_S > MAX_C) ? MAX_S : MAX_C;
   localparam int CNT_W = $clog2(MAX_A + 1);

   if (SETTLE_FAST < 1 || SETTLE_SLOW < 1 || CONV_FAST < 1 || CONV_SLOW < 1) begin : g_bad_cnt
      $error("adcseq_timer: interval counts must be at least 1");
   end

   logic [CNT_W-1:0] settle_q, conv_q;
   logic             ready_q;
   logic             done;

   assign done    = (conv_q == CNT_W'(1)) && (settle_q == '0) && !conv_start && !settle_start;
   assign capture = done && ch_ok;
   assign ready   = ready_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         settle_q <= '0;
         conv_q   <= '0;
         ready_q  <= 1'b0;
      end else begin
         if (settle_start)
            settle_q <= (rate_sel == adcseq_pkg::RATE_SLOW) ? CNT_W'(SETTLE_SLOW) : CNT_W'(SETTLE_FAST);
         else if (settle_q != '0)
            settle_q <= settle_q - 1'b1;

         if (conv_start)
            conv_q <= (rate_sel == adcseq_pkg::RATE_SLOW) ? CNT_W'(CONV_SLOW) : CNT_W'(CONV_FAST);
         else if (conv_q != '0 && settle_q == '0 && !settle_start)
            conv_q <= conv_q - 1'b1;

         if (conv_start || settle_start) ready_q <= 1'b0;
         else if (done)                  ready_q <= ch_ok;
      end
   end

   // R6: no ready flag while the mux is settling
   a_r6_quiet_settle: assert property (@(posedge clk) disable iff (!rst_n)
      (settle_q != '0) |-> !ready_q);
   // R5: a conversion trigger drops ready on the next edge
   a_r5_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !ready_q);
   // R5: ready holds until the next trigger or switch
   a_r5_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_q && !conv_start && !settle_start) |=> ready_q);
endmodule

// File: rtl/adcseq_ctrl.sv
`timescale 1ns/1ps
module adcseq_ctrl #(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 32,
   parameter int SMP_W       = 16,
   parameter int SW_W        = 12,
   parameter bit SAT_EN      = 1'b1,
   parameter int SAT_LIMIT   = 25000,
   parameter int SETTLE_FAST = 6,
   parameter int SETTLE_SLOW = 24,
   parameter int CONV_FAST   = 4,
   parameter int CONV_SLOW   = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         bus_en,
   input  logic                         bus_we,
   input  logic [ADDR_W-1:0]            bus_addr,
   input  logic [DATA_W-1:0]            bus_wdata,
   output logic [DATA_W-1:0]            bus_rdata,
   input  logic                         rate_sel,
   input  logic [SMP_W-1:0]             sample_in,
   output logic [adcseq_pkg::IDX_W-1:0] ch_idx,
   output logic                         ch_ok,
   output logic                         result_ready
);
   localparam logic [ADDR_W-1:0] A_RES = ADDR_W'(adcseq_pkg::OFS_RESULT);
   localparam logic [ADDR_W-1:0] A_SW  = ADDR_W'(adcseq_pkg::OFS_SWITCH);
   localparam int PAD_W = DATA_W - SMP_W - 1;
   localparam logic signed [SMP_W-1:0] LIM_P = SMP_W'(SAT_LIMIT);
   localparam logic signed [SMP_W-1:0] LIM_N = -LIM_P;

   if (PAD_W < 1) begin : g_bad_data_w
      $error("adcseq_ctrl: DATA_W must exceed SMP_W + 1");
   end
   if (SAT_LIMIT < 1 || SAT_LIMIT >= (1 << (SMP_W - 1))) begin : g_bad_limit
      $error("adcseq_ctrl: SAT_LIMIT does not fit the sample width");
   end

   logic [SW_W-1:0]        sw_word;
   logic                   sw_load;
   logic                   rd_res;
   logic                   capture;
   logic signed [SMP_W-1:0] smp_s, smp_fix;
   logic [SMP_W-1:0]       data_q;

   assign rd_res = bus_en && !bus_we && (bus_addr == A_RES);

   adcseq_lock #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SW_W(SW_W)) lock_i (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .sw_word(sw_word), .sw_load(sw_load));

   adcseq_chdec #(.SW_W(SW_W)) dec_i (
      .sw_word(sw_word), .ch_idx(ch_idx), .ch_ok(ch_ok));

   adcseq_timer #(.SETTLE_FAST(SETTLE_FAST), .SETTLE_SLOW(SETTLE_SLOW),
                  .CONV_FAST(CONV_FAST), .CONV_SLOW(CONV_SLOW)) tmr_i (
      .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel),
      .settle_start(sw_load), .conv_start(rd_res), .ch_ok(ch_ok),
      .capture(capture), .ready(result_ready));

   assign smp_s = $signed(sample_in);

   if (SAT_EN) begin : g_sat
      always_comb begin
         if (smp_s > LIM_P)      smp_fix = LIM_P;
         else if (smp_s < LIM_N) smp_fix = LIM_N;
         else                    smp_fix = smp_s;
      end
      // R7: a ready sample never leaves the legal range
      a_r7_in_range: assert property (@(posedge clk) disable iff (!rst_n)
         result_ready |-> ($signed(data_q) <= LIM_P && $signed(data_q) >= LIM_N));
   end else begin : g_raw
      assign smp_fix = smp_s;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       data_q <= '0;
      else if (capture) data_q <= smp_fix;
   end

   always_comb begin
      if (bus_addr == A_RES)     bus_rdata = {result_ready, {PAD_W{1'b0}}, data_q};
      else if (bus_addr == A_SW) bus_rdata = DATA_W'(sw_word);
      else                       bus_rdata = '0;
   end

   // R8: ready only ever rises with a valid channel selected
   a_r8_valid_only: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(result_ready) |-> ch_ok);
endmodule

// File: tb/adcseq_ctrl_tb_top.sv
`timescale 1ns/1ps
module adcseq_ctrl_tb_top;
   localparam int SF = 6, SS = 24, CF = 4, CS = 16;
   localparam logic [7:0] A_RES = 8'h08, A_SW = 8'h18, A_LOCK = 8'h20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_en = 1'b0, bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        rate_sel = 1'b0;
   logic [15:0] sample_in = '0;
   logic [2:0]  ch_idx;
   logic        ch_ok, result_ready;

   int checks = 0, failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   adcseq_ctrl #(.SETTLE_FAST(SF), .SETTLE_SLOW(SS), .CONV_FAST(CF), .CONV_SLOW(CS)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rate_sel(rate_sel),
      .sample_in(sample_in), .ch_idx(ch_idx), .ch_ok(ch_ok), .result_ready(result_ready));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   // all tasks start and end on a falling edge
   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
      bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_en = 1'b0;
   endtask

   task automatic unlock_switch(input logic [31:0] code);
      bus_write(A_LOCK, 32'hAA);
      bus_write(A_SW, code);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      logic [31:0] d;
      chk("R1 ready after reset", {31'b0, result_ready}, 32'h0);
      bus_read(A_RES, d);
      chk("R1 result bit31 after reset", {31'b0, d[31]}, 32'h0);
      bus_read(A_SW, d);
      chk("R1 switch word after reset", d, 32'h0);
      bus_write(A_SW, 32'h608);
      bus_read(A_SW, d);
      chk("R1 locked after reset", d, 32'h0);
   endtask

   task automatic t_lock;
      logic [31:0] d;
      bus_write(A_LOCK, 32'hAA); bus_read(A_RES, d); bus_write(A_SW, 32'h680);
      bus_read(A_SW, d); chk("R2 read between key and write relocks", d, 32'h0);
      bus_write(A_LOCK, 32'h55); bus_write(A_SW, 32'h680);
      bus_read(A_SW, d); chk("R2 wrong key value", d, 32'h0);
      bus_write(8'h1C, 32'hAA); bus_write(A_SW, 32'h680);
      bus_read(A_SW, d); chk("R2 key at wrong address", d, 32'h0);
      bus_write(A_LOCK, 32'hAA); bus_write(A_LOCK, 32'hAA); bus_write(A_SW, 32'h680);
      bus_read(A_SW, d); chk("R3 repeated key then write", d, 32'h680);
      bus_write(A_SW, 32'h640);
      bus_read(A_SW, d); chk("R2 unlock is one-shot", d, 32'h680);
   endtask

   task automatic t_chmap;
      logic [11:0] codes [8] = '{12'h608, 12'h680, 12'h640, 12'h620,
                                 12'h610, 12'h601, 12'h602, 12'h604};
      logic [31:0] d;
      for (int i = 0; i < 8; i++) begin
         unlock_switch({20'h0, codes[i]});
         chk("R4 channel index", {29'b0, ch_idx}, 32'(i));
         chk("R4 channel valid", {31'b0, ch_ok}, 32'h1);
         bus_read(A_SW, d);
         chk("R3 switch readback", d, {20'h0, codes[i]});
      end
   endtask

   task automatic t_conv_fast;
      logic [31:0] d;
      rate_sel = 1'b0;
      unlock_switch(32'h620);
      idle(SF + 2);
      sample_in = 16'd1234;
      bus_read(A_RES, d);
      idle(CF - 1);
      chk("R5 not ready one edge early", {31'b0, result_ready}, 32'h0);
      idle(1);
      chk("R5 ready after CONV edges", {31'b0, result_ready}, 32'h1);
      bus_read(A_RES, d);
      chk("R7 result word positive", d, 32'h8000_04D2);
      // restart: second read inside a running conversion
      sample_in = 16'hFFFB;
      idle(2);
      bus_read(A_RES, d);
      idle(1);
      chk("R5 restarted conversion not ready", {31'b0, result_ready}, 32'h0);
      idle(CF - 2);
      chk("R5 old conversion discarded", {31'b0, result_ready}, 32'h0);
      idle(1);
      chk("R5 ready after restart", {31'b0, result_ready}, 32'h1);
      bus_read(A_RES, d);
      chk("R7 result word negative", d, 32'h8000_FFFB);
   endtask

   task automatic t_settle(input logic slow);
      int s, c;
      logic [31:0] d;
      s = slow ? SS : SF;
      c = slow ? CS : CF;
      rate_sel = slow;
      sample_in = 16'd77;
      unlock_switch(32'h601);
      chk(slow ? "R6 switch clears ready slow" : "R6 switch clears ready fast",
          {31'b0, result_ready}, 32'h0);
      bus_read(A_RES, d);
      idle(s + c - 2);
      chk(slow ? "R9 slow not ready early" : "R6 fast not ready early",
          {31'b0, result_ready}, 32'h0);
      idle(1);
      chk(slow ? "R9 slow ready on time" : "R6 fast ready on time",
          {31'b0, result_ready}, 32'h1);
      rate_sel = 1'b0;
   endtask

   task automatic t_clamp;
      logic [31:0] d;
      unlock_switch(32'h604);
      idle(SF + 1);
      sample_in = 16'd30000;
      bus_read(A_RES, d);
      idle(CF);
      sample_in = 16'h8AD0;
      bus_read(A_RES, d);
      chk("R7 upper clamp", d, 32'h8000_61A8);
      idle(CF);
      bus_read(A_RES, d);
      chk("R7 lower clamp", d, 32'h8000_9E58);
   endtask

   task automatic t_invalid;
      logic [31:0] d;
      unlock_switch(32'h0F0);
      bus_read(A_SW, d);
      chk("R8 invalid word stored", d, 32'h0F0);
      chk("R8 invalid word no channel", {31'b0, ch_ok}, 32'h0);
      bus_read(A_RES, d);
      idle(SF + CF + 4);
      chk("R8 no ready on invalid channel", {31'b0, result_ready}, 32'h0);
      bus_read(A_RES, d);
      chk("R8 result bit31 stays low", {31'b0, d[31]}, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_lock();
      t_chmap();
      t_conv_fast();
      t_settle(1'b0);
      t_settle(1'b1);
      t_clamp();
      t_invalid();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule